// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns an operand reference into a 20-bit physical memory address. It takes the current values of the two base pointers, the two index pointers, a displacement and the four segment registers, all supplied from outside. From these it forms a 16-bit effective offset according to one of five addressing modes. It then picks a segment register, shifts it left by four bits and adds the offset to it.

The segment is chosen by which pointer the mode uses. References through the stack base pointer fall into the stack segment, and every other reference falls into the data segment. A segment override with a valid flag replaces that default choice. The block has no clock and no state, so an address-generation stage can place it directly between its register read and its memory request.

Top module: `seg_addr_gen`

## Requirements
- R1: `phys_addr` equals (segment value × 16 + `eff_ofs`) modulo 2^20.
- R2: With `mode` = 0 (direct), `eff_ofs` equals all 16 bits of `disp`, whatever the value of `disp_wide`, and the default segment is the data segment.
- R3: With `mode` = 1 (register indirect / indexed), `eff_ofs` equals the pointer chosen by `ptr_sel` (0 = BX, 1 = BP, 2 = SI, 3 = DI), and `disp` has no effect.
- R4: With `mode` = 2 (register relative), `eff_ofs` equals the pointer chosen by `ptr_sel` plus the displacement.
- R5: When `disp_wide` = 0, the displacement used is `disp[7:0]` sign-extended to 16 bits, and `disp[15:8]` has no effect. When `disp_wide` = 1, all 16 bits are used.
- R6: With `mode` = 3 (based indexed), `eff_ofs` equals the base register (`base_sel` 0 = BX, 1 = BP) plus the index register (`idx_sel` 0 = SI, 1 = DI), and `disp` has no effect.
- R7: With `mode` = 4 (relative based indexed), `eff_ofs` equals base plus index plus displacement.
- R8: Every offset sum wraps modulo 2^16 before the segment is applied.
- R9: Without an override, `seg_code` is 2 (stack segment) when the mode uses BP, and 3 (data segment) in every other case.
- R10: When `ovr_valid` = 1, the segment is the one named by `ovr_code` (0 = ES, 1 = CS, 2 = SS, 3 = DS), and `seg_code` reports that code.
- R11: The reserved mode codes 5, 6 and 7 behave exactly as direct mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode | input | 3 | Addressing mode code |
| ptr_sel | input | 2 | Single pointer for modes 1 and 2 |
| base_sel | input | 1 | Base register for modes 3 and 4 |
| idx_sel | input | 1 | Index register for modes 3 and 4 |
| disp_wide | input | 1 | 1 = 16-bit displacement, 0 = 8-bit sign-extended displacement |
| disp | input | 16 | Displacement or direct offset |
| reg_bx | input | 16 | BX value |
| reg_bp | input | 16 | BP value |
| reg_si | input | 16 | SI value |
| reg_di | input | 16 | DI value |
| seg_es | input | 16 | ES value |
| seg_cs | input | 16 | CS value |
| seg_ss | input | 16 | SS value |
| seg_ds | input | 16 | DS value |
| ovr_valid | input | 1 | Segment override present |
| ovr_code | input | 2 | Override segment code |
| eff_ofs | output | 16 | Effective offset |
| seg_code | output | 2 | Segment code actually used |
| phys_addr | output | 20 | Physical address |

## Verification
Every result is combinational, so each output is due in the same cycle as its stimulus, with zero register stages on the path. The bench applies a new input vector one time unit after a rising clock edge. It compares the three outputs against its own arithmetic model at the following falling edge, when the logic has settled well before the next vector. Directed vectors cover the wrap points, negative 8-bit displacements, each override code and the reserved modes. Pseudo-random vectors then cover every mode and selector mix.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

  typedef enum logic [2:0] {
    AM_DIRECT   = 3'd0,
    AM_PTR      = 3'd1,
    AM_PTR_DISP = 3'd2,
    AM_BASE_IDX = 3'd3,
    AM_BI_DISP  = 3'd4
  } addr_mode_e;

  typedef enum logic [1:0] {
    SEG_ES = 2'd0,
    SEG_CS = 2'd1,
    SEG_SS = 2'd2,
    SEG_DS = 2'd3
  } seg_code_e;

  localparam int NUM_PTR = 4;
  localparam int NUM_SEG = 4;

  function automatic seg_code_e default_seg(input logic bp_used);
    return bp_used ? SEG_SS : SEG_DS;
  endfunction

endpackage

// File: rtl/ea_offset_sum.sv
module ea_offset_sum
  import seg_addr_pkg::*;
#(
  parameter int OFS_W    = 16,
  parameter int NARROW_W = 8
) (
  input  logic [2:0]       mode,
  input  logic [1:0]       ptr_sel,
  input  logic             base_sel,
  input  logic             idx_sel,
  input  logic             disp_wide,
  input  logic [OFS_W-1:0] disp,
  input  logic [OFS_W-1:0] reg_bx,
  input  logic [OFS_W-1:0] reg_bp,
  input  logic [OFS_W-1:0] reg_si,
  input  logic [OFS_W-1:0] reg_di,
  output logic [OFS_W-1:0] eff_ofs,
  output logic             bp_used
);

  localparam int PAD_W = OFS_W - NARROW_W;

  function automatic logic [OFS_W-1:0] widen_disp(input logic [OFS_W-1:0] d,
                                                  input logic wide);
    if (wide) return d;
    return {{PAD_W{d[NARROW_W-1]}}, d[NARROW_W-1:0]};
  endfunction

  function automatic logic [OFS_W-1:0] add_wrap(input logic [OFS_W-1:0] a,
                                                input logic [OFS_W-1:0] b,
                                                input logic [OFS_W-1:0] c);
    logic [OFS_W-1:0] s;
    s = a + b + c;
    return s;
  endfunction

  addr_mode_e       mode_q;
  logic [OFS_W-1:0] ptr_bank [NUM_PTR];
  logic [OFS_W-1:0] ptr_val;
  logic [OFS_W-1:0] base_val;
  logic [OFS_W-1:0] idx_val;
  logic [OFS_W-1:0] disp_ext;
  logic [OFS_W-1:0] sum_ptr_disp;
  logic [OFS_W-1:0] sum_base_idx;
  logic [OFS_W-1:0] sum_bi_disp;

  assign mode_q = addr_mode_e'(mode);

  // Pointer bank order matches the ptr_sel code.
  assign ptr_bank[0] = reg_bx;
  assign ptr_bank[1] = reg_bp;
  assign ptr_bank[2] = reg_si;
  assign ptr_bank[3] = reg_di;

  assign ptr_val      = ptr_bank[ptr_sel];
  assign base_val     = base_sel ? reg_bp : reg_bx;
  assign idx_val      = idx_sel  ? reg_di : reg_si;
  assign disp_ext     = widen_disp(disp, disp_wide);
  assign sum_ptr_disp = add_wrap(ptr_val, disp_ext, '0);
  assign sum_base_idx = add_wrap(base_val, idx_val, '0);
  assign sum_bi_disp  = add_wrap(base_val, idx_val, disp_ext);

  always_comb begin
    eff_ofs = disp;
    bp_used = 1'b0;
    case (mode_q)
      AM_PTR: begin
        eff_ofs = ptr_val;
        bp_used = (ptr_sel == 2'd1);
      end
      AM_PTR_DISP: begin
        eff_ofs = sum_ptr_disp;
        bp_used = (ptr_sel == 2'd1);
      end
      AM_BASE_IDX: begin
        eff_ofs = sum_base_idx;
        bp_used = base_sel;
      end
      AM_BI_DISP: begin
        eff_ofs = sum_bi_disp;
        bp_used = base_sel;
      end
      default: begin
        eff_ofs = disp;
        bp_used = 1'b0;
      end
    endcase
  end

  always_comb begin
    if (!$isunknown({mode, disp, eff_ofs})) begin
      // R2 / R11: direct and reserved codes pass the full displacement
      if (mode == 3'd0 || mode > 3'd4)
        a_r2_direct_passthru: assert (eff_ofs == disp && !bp_used);
      // R5: a narrow displacement adds a value that depends on its low byte only
      if (mode == 3'd2 && !disp_wide && !$isunknown(ptr_val))
        a_r5_narrow_sext: assert ((eff_ofs - ptr_val) ==
                                  {{PAD_W{disp[NARROW_W-1]}}, disp[NARROW_W-1:0]});
      // R6: based indexed ignores the displacement
      if (mode == 3'd3 && !$isunknown({base_val, idx_val}))
        a_r6_no_disp: assert ((eff_ofs - idx_val) == base_val);
    end
  end

endmodule

// File: rtl/ea_seg_pick.sv
module ea_seg_pick
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = 16
) (
  input  logic             bp_used,
  input  logic             ovr_valid,
  input  logic [1:0]       ovr_code,
  input  logic [SEG_W-1:0] seg_es,
  input  logic [SEG_W-1:0] seg_cs,
  input  logic [SEG_W-1:0] seg_ss,
  input  logic [SEG_W-1:0] seg_ds,
  output logic [SEG_W-1:0] seg_val,
  output logic [1:0]       seg_code
);

  logic [SEG_W-1:0] seg_bank [NUM_SEG];
  logic [SEG_W-1:0] seg_in   [NUM_SEG];
  seg_code_e        dflt;

  assign seg_in[0] = seg_es;
  assign seg_in[1] = seg_cs;
  assign seg_in[2] = seg_ss;
  assign seg_in[3] = seg_ds;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_bank
    assign seg_bank[g] = seg_in[g];
  end

  assign dflt     = default_seg(bp_used);
  assign seg_code = ovr_valid ? ovr_code : 2'(dflt);
  assign seg_val  = seg_bank[seg_code];

  always_comb begin
    if (!$isunknown({bp_used, ovr_valid, ovr_code, seg_code})) begin
      // R10: an override always wins
      if (ovr_valid)
        a_r10_override_wins: assert (seg_code == ovr_code);
      // R9: default choice follows the pointer in use
      if (!ovr_valid)
        a_r9_default_seg: assert (seg_code == (bp_used ? 2'd2 : 2'd3));
    end
  end

endmodule

// File: rtl/ea_phys_form.sv
module ea_phys_form #(
  parameter int OFS_W     = 16,
  parameter int SEG_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int PA_W      = SEG_W + SEG_SHIFT
) (
  input  logic [SEG_W-1:0] seg_val,
  input  logic [OFS_W-1:0] eff_ofs,
  output logic [PA_W-1:0]  phys_addr
);

  function automatic logic [PA_W-1:0] form_pa(input logic [SEG_W-1:0] s,
                                              input logic [OFS_W-1:0] o);
    logic [PA_W-1:0] shifted;
    logic [PA_W-1:0] widened;
    shifted = {s, {SEG_SHIFT{1'b0}}};
    widened = PA_W'(o);
    return shifted + widened;
  endfunction

  assign phys_addr = form_pa(seg_val, eff_ofs);

  always_comb begin
    if (!$isunknown({seg_val, eff_ofs, phys_addr}))
      // R1: the low bits below the segment shift come from the offset alone
      a_r1_low_bits: assert (phys_addr[SEG_SHIFT-1:0] == eff_ofs[SEG_SHIFT-1:0]);
  end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int OFS_W     = 16,
  parameter int SEG_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int NARROW_W  = 8,
  localparam int PA_W     = SEG_W + SEG_SHIFT
) (
  input  logic [2:0]       mode,
  input  logic [1:0]       ptr_sel,
  input  logic             base_sel,
  input  logic             idx_sel,
  input  logic             disp_wide,
  input  logic [OFS_W-1:0] disp,
  input  logic [OFS_W-1:0] reg_bx,
  input  logic [OFS_W-1:0] reg_bp,
  input  logic [OFS_W-1:0] reg_si,
  input  logic [OFS_W-1:0] reg_di,
  input  logic [SEG_W-1:0] seg_es,
  input  logic [SEG_W-1:0] seg_cs,
  input  logic [SEG_W-1:0] seg_ss,
  input  logic [SEG_W-1:0] seg_ds,
  input  logic             ovr_valid,
  input  logic [1:0]       ovr_code,
  output logic [OFS_W-1:0] eff_ofs,
  output logic [1:0]       seg_code,
  output logic [PA_W-1:0]  phys_addr
);

  logic             bp_used;
  logic [SEG_W-1:0] seg_val;

  ea_offset_sum #(.OFS_W(OFS_W), .NARROW_W(NARROW_W)) u_ofs (
    .mode(mode), .ptr_sel(ptr_sel), .base_sel(base_sel), .idx_sel(idx_sel),
    .disp_wide(disp_wide), .disp(disp),
    .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
    .eff_ofs(eff_ofs), .bp_used(bp_used)
  );

  ea_seg_pick #(.SEG_W(SEG_W)) u_seg (
    .bp_used(bp_used), .ovr_valid(ovr_valid), .ovr_code(ovr_code),
    .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
    .seg_val(seg_val), .seg_code(seg_code)
  );

  ea_phys_form #(.OFS_W(OFS_W), .SEG_W(SEG_W), .SEG_SHIFT(SEG_SHIFT),
                 .PA_W(PA_W)) u_pa (
    .seg_val(seg_val), .eff_ofs(eff_ofs), .phys_addr(phys_addr)
  );

  always_comb begin
    if (!$isunknown({mode, ptr_sel, disp, reg_bx, reg_bp, reg_si, reg_di, eff_ofs}))
      // R3: single-pointer mode returns the selected pointer untouched
      if (mode == 3'd1)
        a_r3_ptr_only: assert (eff_ofs == (ptr_sel == 2'd0 ? reg_bx :
                                           ptr_sel == 2'd1 ? reg_bp :
                                           ptr_sel == 2'd2 ? reg_si : reg_di));
  end

endmodule

// File: tb/seg_addr_gen_bench.sv
module seg_addr_gen_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [2:0]  mode;
  logic [1:0]  ptr_sel;
  logic        base_sel, idx_sel, disp_wide;
  logic [15:0] disp, reg_bx, reg_bp, reg_si, reg_di;
  logic [15:0] seg_es, seg_cs, seg_ss, seg_ds;
  logic        ovr_valid;
  logic [1:0]  ovr_code;
  logic [15:0] eff_ofs;
  logic [1:0]  seg_code;
  logic [19:0] phys_addr;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  logic [31:0] rng = 32'h1234_5678;

  seg_addr_gen u_seg_addr_gen (
    .mode(mode), .ptr_sel(ptr_sel), .base_sel(base_sel), .idx_sel(idx_sel),
    .disp_wide(disp_wide), .disp(disp),
    .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
    .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
    .ovr_valid(ovr_valid), .ovr_code(ovr_code),
    .eff_ofs(eff_ofs), .seg_code(seg_code), .phys_addr(phys_addr)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      n_fail = n_fail + 1;
      n_checks = n_checks + 1;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 20000", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  function automatic logic [31:0] next_rng(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  // Behavioural model: integer arithmetic straight from the requirements.
  task automatic model(output int exp_ofs, output int exp_seg, output int exp_pa);
    int d, p, b, x, sv;
    bit via_bp;
    d = disp_wide ? int'(disp) : (int'(disp[7:0]) >= 128 ? int'(disp[7:0]) - 256
                                                         : int'(disp[7:0]));
    case (ptr_sel)
      2'd0: p = reg_bx;
      2'd1: p = reg_bp;
      2'd2: p = reg_si;
      default: p = reg_di;
    endcase
    b = base_sel ? int'(reg_bp) : int'(reg_bx);
    x = idx_sel ? int'(reg_di) : int'(reg_si);
    via_bp = 1'b0;
    if (mode == 1) begin exp_ofs = p; via_bp = (ptr_sel == 1); end
    else if (mode == 2) begin exp_ofs = p + d; via_bp = (ptr_sel == 1); end
    else if (mode == 3) begin exp_ofs = b + x; via_bp = base_sel; end
    else if (mode == 4) begin exp_ofs = b + x + d; via_bp = base_sel; end
    else exp_ofs = disp;
    exp_ofs = ((exp_ofs % 65536) + 65536) % 65536;
    exp_seg = ovr_valid ? int'(ovr_code) : (via_bp ? 2 : 3);
    case (exp_seg)
      0: sv = seg_es;
      1: sv = seg_cs;
      2: sv = seg_ss;
      default: sv = seg_ds;
    endcase
    exp_pa = (sv * 16 + exp_ofs) % 1048576;
  endtask

  task automatic check(input string tag);
    int eo, es, ep;
    @(negedge clk);
    model(eo, es, ep);
    n_checks = n_checks + 1;
    if (int'(eff_ofs) != eo || int'(seg_code) != es || int'(phys_addr) != ep) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual ofs=%h seg=%0d pa=%h expected ofs=%h seg=%0d pa=%h",
               tag, eff_ofs, seg_code, phys_addr, eo[15:0], es, ep[19:0]);
    end
  endtask

  task automatic apply_start;
    @(posedge clk);
    #1;
  endtask

  task automatic set_regs(input logic [15:0] bx, bp, si, di);
    reg_bx = bx; reg_bp = bp; reg_si = si; reg_di = di;
  endtask

  task automatic set_segs(input logic [15:0] es, cs, ss, ds);
    seg_es = es; seg_cs = cs; seg_ss = ss; seg_ds = ds;
  endtask

  task automatic set_op(input logic [2:0] m, input logic [1:0] ps, input logic bs,
                        input logic is, input logic w, input logic [15:0] d,
                        input logic ov, input logic [1:0] oc);
    mode = m; ptr_sel = ps; base_sel = bs; idx_sel = is;
    disp_wide = w; disp = d; ovr_valid = ov; ovr_code = oc;
  endtask

  initial begin
    set_regs(16'h0, 16'h0, 16'h0, 16'h0);
    set_segs(16'h0, 16'h0, 16'h0, 16'h0);
    set_op(3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 2'd0);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // All-zero state: direct, zero address, data segment (R1, R2)
    check("R2 idle zero");

    apply_start;
    set_regs(16'h2000, 16'h0400, 16'h3000, 16'h1000);
    set_segs(16'h1111, 16'h2222, 16'h3333, 16'h4444);
    set_op(3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 16'h5000, 1'b0, 2'd0);
    check("R2 direct narrow flag ignored");

    apply_start; set_op(3'd1, 2'd0, 1'b0, 1'b0, 1'b1, 16'hBEEF, 1'b0, 2'd0);
    check("R3 indirect via BX");
    apply_start; set_op(3'd1, 2'd2, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b0, 2'd0);
    check("R3 indexed via SI");
    apply_start; set_op(3'd1, 2'd1, 1'b0, 1'b0, 1'b0, 16'h7777, 1'b0, 2'd0);
    check("R9 indirect via BP uses stack seg");

    apply_start; set_op(3'd2, 2'd0, 1'b0, 1'b0, 1'b1, 16'h3000, 1'b0, 2'd0);
    check("R4 relative BX + wide");
    apply_start; set_op(3'd2, 2'd3, 1'b0, 1'b0, 1'b0, 16'hAB80, 1'b0, 2'd0);
    check("R5 narrow 0x80 is -128, upper byte ignored");
    apply_start; set_op(3'd2, 2'd2, 1'b0, 1'b0, 1'b0, 16'hFF7F, 1'b0, 2'd0);
    check("R5 narrow 0x7F positive");

    apply_start; set_op(3'd3, 2'd0, 1'b0, 1'b0, 1'b0, 16'h1234, 1'b0, 2'd0);
    check("R6 BX+SI");
    apply_start; set_op(3'd3, 2'd0, 1'b1, 1'b1, 1'b1, 16'h9999, 1'b0, 2'd0);
    check("R6 BP+DI stack seg");

    apply_start; set_op(3'd4, 2'd0, 1'b0, 1'b0, 1'b1, 16'h2000, 1'b0, 2'd0);
    check("R7 BX+SI+wide");
    apply_start; set_op(3'd4, 2'd0, 1'b1, 1'b0, 1'b0, 16'h00F0, 1'b0, 2'd0);
    check("R7 BP+SI+narrow negative");

    apply_start;
    set_regs(16'hFFFF, 16'hFFF0, 16'h0002, 16'hFFFF);
    set_op(3'd3, 2'd0, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 2'd0);
    check("R8 offset wraps 0xFFFF+2");
    apply_start; set_op(3'd4, 2'd0, 1'b1, 1'b1, 1'b1, 16'hFFFF, 1'b0, 2'd0);
    check("R8 triple sum wraps");

    apply_start;
    set_segs(16'hFFFF, 16'hF000, 16'h0001, 16'hFFFF);
    set_regs(16'h0010, 16'h0, 16'h0, 16'h0);
    set_op(3'd1, 2'd0, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 2'd0);
    check("R1 physical wraps at 1 MiB");
    apply_start; set_op(3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 16'hFFFF, 1'b1, 2'd1);
    check("R1 top address, R10 override CS");

    for (int c = 0; c < 4; c++) begin
      apply_start;
      set_segs(16'h0100, 16'h0200, 16'h0300, 16'h0400);
      set_op(3'd1, 2'd1, 1'b0, 1'b0, 1'b0, 16'h0, 1'b1, 2'(c));
      check("R10 override replaces stack default");
    end

    for (int m = 5; m < 8; m++) begin
      apply_start;
      set_op(3'(m), 2'd1, 1'b1, 1'b1, 1'b0, 16'hC0DE, 1'b0, 2'd0);
      check("R11 reserved mode acts direct");
    end

    for (int i = 0; i < 600; i++) begin
      apply_start;
      rng = next_rng(rng); set_regs(rng[15:0], rng[31:16], 16'h0, 16'h0);
      rng = next_rng(rng); reg_si = rng[15:0]; reg_di = rng[31:16];
      rng = next_rng(rng); set_segs(rng[15:0], rng[31:16], 16'h0, 16'h0);
      rng = next_rng(rng); seg_ss = rng[15:0]; seg_ds = rng[31:16];
      rng = next_rng(rng);
      set_op(3'(rng[2:0] % 5), rng[4:3], rng[5], rng[6], rng[7], rng[31:16],
             rng[8] & rng[9], rng[11:10]);
      check("R4 R7 R9 random mix");
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule